// File: doc/BRIEF.md
# Hardware Trap Sequencer

This block takes fault and event pulses from a small 16-bit processor core and turns them into trap entries. Each request is held pending until it is serviced, and no mask can block it. While the block is idle it picks one winner under a fixed priority. Every trap entry produces the same outputs:

- a strobe that marks the entry;
- the handler address;
- a replacement status word;
- a strobe that zeroes the code segment pointer;
- a run of stack writes that save the context.

A return-from-trap request reverses the save. It reads the saved words back off the stack and presents them as a restored context. The stack storage, instruction decoding and the ordinary interrupt arbiter lie outside the block.

The fault sources fall into three groups:

- **First group:** the external non-maskable event and the two stack-limit faults. These share one priority rank, but each has its own handler address.
- **Second group:** the five access and decode faults. These share one rank and one handler. A sticky flag per source tells that handler which fault fired, and software clears a flag by writing a one to it.
- **Debug event:** this sits above both groups, with its own rank and its own handler.

A software trap request is also accepted. It enters without raising the priority level.

Top module: `trap_ctrl_top`

## Requirements
- R1: Each pulse on `hwTrapReq` is latched pending until it is serviced, and no input masks it. The bit map is: 0 external non-maskable event, 1 stack overflow, 2 stack underflow, 3 undefined opcode, 4 protection fault, 5 misaligned word operand, 6 bad instruction fetch, 7 bad external bus access, 8 debug. A request is taken at the earliest one cycle after its pulse. `trapTaken` is high for exactly one cycle per entry.
- R2: A single winner is chosen from the pending requests in this order: debug, then bit 0, bit 1, bit 2, then any of bits 3..7, then the software trap, then return. Losing requests stay pending and are served later in the same order.
- R3: `trapVector`, valid while `trapTaken` is high, takes these values: debug 0x20, bit 0 0x08, bit 1 0x10, bit 2 0x18, any of bits 3..7 0x28. A software trap uses the `swTrapVec` value latched with its request.
- R4: One entry serves all pending requests on bits 3..7 together.
- R5: `classBFlags[i]` is set in the cycle after a pulse on `hwTrapReq[3+i]`. It is cleared by a one on `flagClr[i]`. A set in the same cycle as a clear wins.
- R6: Starting in the `trapTaken` cycle, `pushValid` is high for consecutive cycles. `pushData` carries the status word, then the zero-extended segment pointer (only when `segEnable` was high when the trap was chosen), then the instruction pointer.
- R7: `newPswValid` is high with `trapTaken`. For a hardware trap, `newPsw` is the captured status word with bits 15:12 set to 15. For a software trap, `newPsw` equals the captured word unchanged.
- R8: `cspClear` is high with `trapTaken` exactly when `segEnable` was high at selection.
- R9: A return request pops, on consecutive `popValid` cycles, the instruction pointer, then the segment pointer (only when `segEnable` was high at selection), then the status word. `popData` is sampled in each of those cycles. In the next cycle `restoreValid` is high with the three values, and `restoreCsp` is 0 when no segment word was popped.
- R10: Only one push or pop sequence runs at a time. At least one idle cycle separates consecutive sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hwTrapReq | input | 9 | Hardware trap request pulses, bit map in R1 |
| swTrapReq | input | 1 | Software trap request pulse |
| swTrapVec | input | 16 | Handler address for the software trap |
| retiReq | input | 1 | Return-from-trap request pulse |
| cpuPsw | input | 16 | Current status word |
| cpuCsp | input | 8 | Current code segment pointer |
| cpuIp | input | 16 | Current instruction pointer |
| segEnable | input | 1 | Segmented addressing active |
| popData | input | 16 | Word read from the stack during a pop cycle |
| flagClr | input | 5 | Write-one-to-clear for the group flags |
| trapTaken | output | 1 | Trap entry strobe |
| trapVector | output | 16 | Handler address |
| newPswValid | output | 1 | Replacement status word is valid |
| newPsw | output | 16 | Replacement status word |
| cspClear | output | 1 | Force the code segment pointer to 0 |
| pushValid | output | 1 | Stack write strobe |
| pushData | output | 16 | Word to write |
| popValid | output | 1 | Stack read strobe |
| restoreValid | output | 1 | Restored context is valid |
| restorePsw | output | 16 | Restored status word |
| restoreCsp | output | 8 | Restored segment pointer |
| restoreIp | output | 16 | Restored instruction pointer |
| classBFlags | output | 5 | Sticky flags for bits 3..7 |

## Verification
A request pulse sampled at edge k becomes pending at that edge. The earliest entry shows `trapTaken`, the first push and the new status word after edge k+1. Each further push or pop follows one edge later. The restored context appears one edge after the last pop, and flag changes appear one edge after their cause. The bench keeps a cycle-exact queue of expected per-cycle records, built when the model decides an entry from the pending set it holds before each edge. After every edge it compares all outputs one nanosecond later, so each result is checked in exactly the cycle it is due.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int NUM_HW = 9;
  localparam int B_NMI  = 0;
  localparam int B_OVF  = 1;
  localparam int B_UNF  = 2;
  localparam int CLB_LO = 3;
  localparam int CLB_HI = 7;
  localparam int B_DBG  = 8;
  localparam int NUM_CLB = CLB_HI - CLB_LO + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PSW, ST_PUSH_CSP, ST_PUSH_IP,
    ST_POP_IP, ST_POP_CSP, ST_POP_PSW, ST_RESTORE
  } seq_state_t;

  typedef enum logic [2:0] {SRC_DBG, SRC_NMI, SRC_OVF, SRC_UNF, SRC_CLB, SRC_SW} trap_src_t;

  typedef enum logic [1:0] {SEL_PSW, SEL_CSP, SEL_IP} push_sel_t;

  typedef struct packed {
    logic      capture;
    trap_src_t src;
    logic      forceLvl;
    push_sel_t pushSel;
    logic      popIp;
    logic      popCsp;
    logic      popPsw;
  } dp_strobe_t;
endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] hwTrapReq,
  input  logic              swTrapReq,
  input  logic              retiReq,
  input  logic              segEnable,
  output dp_strobe_t        strobe,
  output logic              trapTaken,
  output logic              cspClear,
  output logic              pushValid,
  output logic              popValid,
  output logic              restoreValid
);
  logic [NUM_HW-1:0] pend, clrMask;
  logic swPend, retiPend, segSnap, hwSnap;
  logic pickHw, pickSw, pickReti, takeTrap, takeReti;
  trap_src_t pick;
  seq_state_t state, stateNext;

  // fixed-priority winner over the pending set
  always_comb begin
    pick = SRC_DBG; clrMask = '0;
    pickHw = 1'b0; pickSw = 1'b0; pickReti = 1'b0;
    if (pend[B_DBG]) begin
      pick = SRC_DBG; clrMask[B_DBG] = 1'b1; pickHw = 1'b1;
    end else if (pend[B_NMI]) begin
      pick = SRC_NMI; clrMask[B_NMI] = 1'b1; pickHw = 1'b1;
    end else if (pend[B_OVF]) begin
      pick = SRC_OVF; clrMask[B_OVF] = 1'b1; pickHw = 1'b1;
    end else if (pend[B_UNF]) begin
      pick = SRC_UNF; clrMask[B_UNF] = 1'b1; pickHw = 1'b1;
    end else if (|pend[CLB_HI:CLB_LO]) begin
      pick = SRC_CLB; clrMask[CLB_HI:CLB_LO] = '1; pickHw = 1'b1;
    end else if (swPend) begin
      pick = SRC_SW; pickSw = 1'b1;
    end else if (retiPend) begin
      pickReti = 1'b1;
    end
  end

  assign takeTrap = (state == ST_IDLE) && (pickHw || pickSw);
  assign takeReti = (state == ST_IDLE) && pickReti;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (takeTrap) stateNext = ST_PUSH_PSW;
                   else if (takeReti) stateNext = ST_POP_IP;
      ST_PUSH_PSW: stateNext = segSnap ? ST_PUSH_CSP : ST_PUSH_IP;
      ST_PUSH_CSP: stateNext = ST_PUSH_IP;
      ST_PUSH_IP:  stateNext = ST_IDLE;
      ST_POP_IP:   stateNext = segSnap ? ST_POP_CSP : ST_POP_PSW;
      ST_POP_CSP:  stateNext = ST_POP_PSW;
      ST_POP_PSW:  stateNext = ST_RESTORE;
      ST_RESTORE:  stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pend     <= '0;
      swPend   <= 1'b0;
      retiPend <= 1'b0;
      segSnap  <= 1'b0;
      hwSnap   <= 1'b0;
    end else begin
      state    <= stateNext;
      pend     <= (pend & ~(takeTrap ? clrMask : '0)) | hwTrapReq;
      swPend   <= (swPend & ~(takeTrap && pickSw)) | swTrapReq;
      retiPend <= (retiPend & ~takeReti) | retiReq;
      if (takeTrap || takeReti) segSnap <= segEnable;
      if (takeTrap) hwSnap <= pickHw;
    end
  end

  always_comb begin
    strobe.capture  = takeTrap;
    strobe.src      = pick;
    strobe.forceLvl = hwSnap;
    strobe.pushSel  = (state == ST_PUSH_CSP) ? SEL_CSP :
                      (state == ST_PUSH_IP)  ? SEL_IP : SEL_PSW;
    strobe.popIp    = (state == ST_POP_IP);
    strobe.popCsp   = (state == ST_POP_CSP);
    strobe.popPsw   = (state == ST_POP_PSW);
  end

  assign trapTaken    = (state == ST_PUSH_PSW);
  assign cspClear     = trapTaken && segSnap;
  assign pushValid    = (state == ST_PUSH_PSW) || (state == ST_PUSH_CSP) || (state == ST_PUSH_IP);
  assign popValid     = (state == ST_POP_IP) || (state == ST_POP_CSP) || (state == ST_POP_PSW);
  assign restoreValid = (state == ST_RESTORE);
endmodule

// File: rtl/trap_ctx_path.sv
module trap_ctx_path
  import trap_ctrl_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int CSP_W   = 8,
  parameter int LVL_LSB = 12,
  parameter int LVL_W   = 4,
  parameter logic [ADDR_W-1:0] VEC_NMI = 'h08,
  parameter logic [ADDR_W-1:0] VEC_OVF = 'h10,
  parameter logic [ADDR_W-1:0] VEC_UNF = 'h18,
  parameter logic [ADDR_W-1:0] VEC_DBG = 'h20,
  parameter logic [ADDR_W-1:0] VEC_CLB = 'h28
)(
  input  logic               clk,
  input  logic               rstN,
  input  dp_strobe_t         strobe,
  input  logic               swTrapReq,
  input  logic [ADDR_W-1:0]  swTrapVec,
  input  logic [DATA_W-1:0]  cpuPsw,
  input  logic [CSP_W-1:0]   cpuCsp,
  input  logic [DATA_W-1:0]  cpuIp,
  input  logic [DATA_W-1:0]  popData,
  input  logic [NUM_CLB-1:0] classBReq,
  input  logic [NUM_CLB-1:0] flagClr,
  output logic [ADDR_W-1:0]  trapVector,
  output logic [DATA_W-1:0]  newPsw,
  output logic [DATA_W-1:0]  pushData,
  output logic [DATA_W-1:0]  restorePsw,
  output logic [CSP_W-1:0]   restoreCsp,
  output logic [DATA_W-1:0]  restoreIp,
  output logic [NUM_CLB-1:0] classBFlags
);
  localparam int PAD_W = DATA_W - CSP_W;

  logic [ADDR_W-1:0] swVecHold, vecReg;
  logic [DATA_W-1:0] pswSnap, ipSnap;
  logic [CSP_W-1:0]  cspSnap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swVecHold <= '0; vecReg <= '0;
      pswSnap <= '0; ipSnap <= '0; cspSnap <= '0;
      restorePsw <= '0; restoreCsp <= '0; restoreIp <= '0;
    end else begin
      if (swTrapReq) swVecHold <= swTrapVec;
      if (strobe.capture) begin
        pswSnap <= cpuPsw;
        cspSnap <= cpuCsp;
        ipSnap  <= cpuIp;
        unique case (strobe.src)
          SRC_DBG: vecReg <= VEC_DBG;
          SRC_NMI: vecReg <= VEC_NMI;
          SRC_OVF: vecReg <= VEC_OVF;
          SRC_UNF: vecReg <= VEC_UNF;
          SRC_CLB: vecReg <= VEC_CLB;
          default: vecReg <= swVecHold;
        endcase
      end
      if (strobe.popIp) begin
        restoreIp  <= popData;
        restoreCsp <= '0;
      end
      if (strobe.popCsp) restoreCsp <= popData[CSP_W-1:0];
      if (strobe.popPsw) restorePsw <= popData;
    end
  end

  always_comb begin
    newPsw = pswSnap;
    if (strobe.forceLvl) newPsw[LVL_LSB +: LVL_W] = '1;
  end

  always_comb begin
    unique case (strobe.pushSel)
      SEL_CSP: pushData = {{PAD_W{1'b0}}, cspSnap};
      SEL_IP:  pushData = ipSnap;
      default: pushData = pswSnap;
    endcase
  end

  assign trapVector = vecReg;

  // one sticky flag per shared-handler source
  for (genvar i = 0; i < NUM_CLB; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) classBFlags[i] <= 1'b0;
      else       classBFlags[i] <= (classBFlags[i] & ~flagClr[i]) | classBReq[i];
    end
  end
endmodule

// File: rtl/trap_ctrl_top.sv
module trap_ctrl_top
  import trap_ctrl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CSP_W  = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_HW-1:0]  hwTrapReq,
  input  logic               swTrapReq,
  input  logic [ADDR_W-1:0]  swTrapVec,
  input  logic               retiReq,
  input  logic [DATA_W-1:0]  cpuPsw,
  input  logic [CSP_W-1:0]   cpuCsp,
  input  logic [DATA_W-1:0]  cpuIp,
  input  logic               segEnable,
  input  logic [DATA_W-1:0]  popData,
  input  logic [NUM_CLB-1:0] flagClr,
  output logic               trapTaken,
  output logic [ADDR_W-1:0]  trapVector,
  output logic               newPswValid,
  output logic [DATA_W-1:0]  newPsw,
  output logic               cspClear,
  output logic               pushValid,
  output logic [DATA_W-1:0]  pushData,
  output logic               popValid,
  output logic               restoreValid,
  output logic [DATA_W-1:0]  restorePsw,
  output logic [CSP_W-1:0]   restoreCsp,
  output logic [DATA_W-1:0]  restoreIp,
  output logic [NUM_CLB-1:0] classBFlags
);
  dp_strobe_t strobe;

  trap_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hwTrapReq(hwTrapReq), .swTrapReq(swTrapReq),
    .retiReq(retiReq), .segEnable(segEnable), .strobe(strobe),
    .trapTaken(trapTaken), .cspClear(cspClear), .pushValid(pushValid),
    .popValid(popValid), .restoreValid(restoreValid)
  );

  trap_ctx_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CSP_W(CSP_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swTrapReq(swTrapReq),
    .swTrapVec(swTrapVec), .cpuPsw(cpuPsw), .cpuCsp(cpuCsp), .cpuIp(cpuIp),
    .popData(popData), .classBReq(hwTrapReq[CLB_HI:CLB_LO]), .flagClr(flagClr),
    .trapVector(trapVector), .newPsw(newPsw), .pushData(pushData),
    .restorePsw(restorePsw), .restoreCsp(restoreCsp), .restoreIp(restoreIp),
    .classBFlags(classBFlags)
  );

  assign newPswValid = trapTaken;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_CLB-1:0] classBReq,
  input logic [NUM_CLB-1:0] classBFlags,
  input logic               trapTaken,
  input logic               newPswValid,
  input logic               cspClear,
  input logic               pushValid,
  input logic               popValid,
  input logic               restoreValid
);
  AST_ENTRY_PUSHES: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> pushValid && newPswValid); // R6
  AST_TAKEN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> pushValid && !trapTaken); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && popValid)); // R10
  AST_GAP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pushValid) |-> !trapTaken && !popValid); // R10
  AST_RESTORE_AFTER_POP: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |-> $past(popValid) && !popValid); // R9
  AST_SEG_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    cspClear |-> trapTaken); // R8

  for (genvar i = 0; i < NUM_CLB; i++) begin : g_flagChk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      classBReq[i] |=> classBFlags[i]); // R5
  end
endmodule

bind trap_ctrl_top trap_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .classBReq(hwTrapReq[7:3]), .classBFlags(classBFlags),
  .trapTaken(trapTaken), .newPswValid(newPswValid), .cspClear(cspClear),
  .pushValid(pushValid), .popValid(popValid), .restoreValid(restoreValid)
);

// File: tb/tb_trap_ctrl_top.sv
`timescale 1ns/1ps
module tb_trap_ctrl_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0]  hwTrapReq = '0;
  logic        swTrapReq = 1'b0;
  logic [15:0] swTrapVec = '0;
  logic        retiReq = 1'b0;
  logic [15:0] cpuPsw = '0;
  logic [7:0]  cpuCsp = '0;
  logic [15:0] cpuIp = '0;
  logic        segEnable = 1'b0;
  logic [15:0] popData = '0;
  logic [4:0]  flagClr = '0;
  logic        trapTaken, newPswValid, cspClear, pushValid, popValid, restoreValid;
  logic [15:0] trapVector, newPsw, pushData, restorePsw, restoreIp;
  logic [7:0]  restoreCsp;
  logic [4:0]  classBFlags;

  always #2.5 clk = ~clk;

  trap_ctrl_top dut (.*);

  typedef struct packed {
    logic tk; logic [15:0] vec; logic [15:0] npsw; logic cclr;
    logic pv; logic [15:0] pd; logic popv; logic rv;
    logic [15:0] rpsw; logic [7:0] rcsp; logic [15:0] rip;
  } rec_t;

  rec_t q[$];
  logic [15:0] stk[$];
  rec_t cur = '0;
  logic curBusy = 1'b0;
  logic [8:0]  mPend = '0;
  logic        mSw = 1'b0, mReti = 1'b0;
  logic [15:0] mSwVec = '0;
  logic [4:0]  mFlags = '0;
  int nCmp = 0, nBad = 0;
  logic done = 1'b0;

  function automatic void chk(string what, string rq, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endfunction

  task automatic buildTrap(logic [15:0] vec, logic hw);
    rec_t r;
    r = '0; r.tk = 1; r.vec = vec; r.cclr = segEnable; r.pv = 1; r.pd = cpuPsw;
    r.npsw = hw ? (cpuPsw | 16'hF000) : cpuPsw;
    q.push_back(r);
    if (segEnable) begin r = '0; r.pv = 1; r.pd = {8'h00, cpuCsp}; q.push_back(r); end
    r = '0; r.pv = 1; r.pd = cpuIp; q.push_back(r);
  endtask

  task automatic buildReti();
    rec_t r;
    int n = stk.size();
    logic [15:0] ip, ps; logic [7:0] cs;
    ip = stk[n-1];
    cs = segEnable ? stk[n-2][7:0] : 8'h00;
    ps = segEnable ? stk[n-3] : stk[n-2];
    for (int i = 0; i < (segEnable ? 3 : 2); i++) begin r = '0; r.popv = 1; q.push_back(r); end
    r = '0; r.rv = 1; r.rpsw = ps; r.rcsp = cs; r.rip = ip; q.push_back(r);
  endtask

  // model of one clock edge, using the inputs the design samples at that edge
  task automatic modelEdge();
    logic [8:0] clr = '0;
    logic clrSw = 0, clrReti = 0;
    if (curBusy && cur.pv) stk.push_back(cur.pd);
    if (!curBusy) begin
      if (mPend[8])      begin buildTrap(16'h20, 1); clr[8] = 1; end
      else if (mPend[0]) begin buildTrap(16'h08, 1); clr[0] = 1; end
      else if (mPend[1]) begin buildTrap(16'h10, 1); clr[1] = 1; end
      else if (mPend[2]) begin buildTrap(16'h18, 1); clr[2] = 1; end
      else if (|mPend[7:3]) begin buildTrap(16'h28, 1); clr[7:3] = '1; end
      else if (mSw)      begin buildTrap(mSwVec, 0); clrSw = 1; end
      else if (mReti)    begin buildReti(); clrReti = 1; end
    end
    if (q.size() > 0) begin cur = q.pop_front(); curBusy = 1; end
    else begin cur = '0; curBusy = 0; end
    mPend  = (mPend & ~clr) | hwTrapReq;
    mSw    = (mSw & ~clrSw) | swTrapReq;
    mReti  = (mReti & ~clrReti) | retiReq;
    if (swTrapReq) mSwVec = swTrapVec;
    mFlags = (mFlags & ~flagClr) | hwTrapReq[7:3];
  endtask

  task automatic compareAll();
    chk("trapTaken", "R1", trapTaken, cur.tk);
    if (cur.tk) chk("trapVector", "R3", trapVector, cur.vec);
    chk("newPswValid", "R7", newPswValid, cur.tk);
    if (cur.tk) chk("newPsw", "R7", newPsw, cur.npsw);
    chk("cspClear", "R8", cspClear, cur.cclr);
    chk("pushValid", "R6", pushValid, cur.pv);
    if (cur.pv) chk("pushData", "R6", pushData, cur.pd);
    chk("popValid", "R9", popValid, cur.popv);
    chk("restoreValid", "R9", restoreValid, cur.rv);
    if (cur.rv) begin
      chk("restorePsw", "R9", restorePsw, cur.rpsw);
      chk("restoreCsp", "R9", restoreCsp, cur.rcsp);
      chk("restoreIp", "R9", restoreIp, cur.rip);
    end
    chk("classBFlags", "R5", classBFlags, mFlags);
  endtask

  task automatic tick();
    if (curBusy && cur.popv) popData = stk.pop_back(); else popData = '0;
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
    hwTrapReq = '0; swTrapReq = 0; retiReq = 0; flagClr = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setCtx(logic [15:0] p, logic [7:0] c, logic [15:0] i, logic s);
    cpuPsw = p; cpuCsp = c; cpuIp = i; segEnable = s;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state
    chk("reset outputs", "R1",
        {trapTaken, pushValid, popValid, restoreValid, cspClear, newPswValid}, '0);
    chk("reset flags", "R5", classBFlags, '0);
    idle(2);

    // R1 R3 R6 R7: single NMI, no segmentation
    setCtx(16'h0123, 8'h45, 16'h6789, 0);
    hwTrapReq = 9'b000000001; tick(); idle(6);
    // R3 R6 R8: each first-group source and debug with segmentation
    setCtx(16'h2A00, 8'h3C, 16'h1000, 1);
    hwTrapReq = 9'b000000010; tick(); idle(6);
    hwTrapReq = 9'b000000100; tick(); idle(6);
    hwTrapReq = 9'b100000000; tick(); idle(6);
    // R4 R5: second-group source
    hwTrapReq = 9'b000010000; tick(); idle(6);
    // R2 R4: all nine at once; order debug, bit0, bit1, bit2, one shared entry
    setCtx(16'h0F0F, 8'h11, 16'h2222, 0);
    hwTrapReq = 9'h1FF; tick(); idle(30);
    // R5: partial clear, then set and clear of the same bit together
    flagClr = 5'b00101; tick();
    flagClr = 5'b00010; hwTrapReq = 9'b000010000; tick(); idle(8);
    flagClr = 5'b11111; tick(); idle(2);
    // R7 R8: software trap with segmentation, level untouched
    setCtx(16'h3456, 8'h77, 16'h4444, 1);
    swTrapVec = 16'h0100; swTrapReq = 1; tick(); idle(6);
    // R9: return with segmentation pops three words
    retiReq = 1; tick(); idle(7);
    // R10: trap arriving during a running sequence is held
    setCtx(16'h0001, 8'h02, 16'h0003, 0);
    hwTrapReq = 9'b000000001; tick();
    tick();
    hwTrapReq = 9'b001000000; tick(); idle(10);
    // R2: software trap and hardware trap together, hardware first
    swTrapVec = 16'h0200; swTrapReq = 1; hwTrapReq = 9'b000000100; tick(); idle(12);
    // R9: return without segmentation, two pops, restored segment 0
    segEnable = 0; retiReq = 1; tick(); idle(6);
    // R2: return and a trap requested together, trap first
    retiReq = 1; hwTrapReq = 9'b010000000; tick(); idle(14);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule